// File: doc/BRIEF.md
# Watchdog / Interval Timer with Dual Prescaler

This block is an 8-bit up-counter that can serve as a periodic interval timer or as a system watchdog. The count advances on ticks taken from one of two free-running divider chains. The first chain divides the main clock. The second divides a slow sub-clock, which arrives as a one-cycle enable pulse that is synchronous to the main clock. A 3-bit code picks the ratio within the chosen chain. When the counter wraps from 0xFF to 0x00 it sets an overflow flag. In interval mode the flag drives an interrupt request. In watchdog mode it drives either a non-maskable interrupt request or a one-cycle internal reset pulse. The reset pulse returns the whole block to its power-up state.

Software reaches two registers over a simple synchronous bus: a control/status register at address 0 and the counter at address 1. Every write carries a key in the upper byte of its data word. A write whose key does not match leaves the register unchanged. Software clears the overflow flag by first reading the status register while the flag is set and then writing 0 to the flag bit. Software can also clear the flag by turning the timer off.

Top module: `wdt_timer`

## Requirements
- R1: Each prescaled tick increments the counter. A tick taken at 0xFF wraps the counter to 0x00 and sets the overflow flag, which is bit 7 of the control/status register.
- R2: While the enable bit (bit 5) is 0, the counter reads 0x00 and does not count. Writing 1 to the enable bit starts counting.
- R3: Writing 0 to the flag bit clears the flag only if a status read that saw the flag set came before the write. A write of 0 with no such read leaves the flag set, and writing 1 to the flag never changes it.
- R4: A keyed status write with the enable bit at 0 clears the overflow flag, whether or not a status read came before it.
- R5: When bit 6 is 0 (interval mode), irqInterval follows the overflow flag, and nmiReq and rstReq stay low.
- R6: When bit 6 is 1 (watchdog mode) and bit 3 is 0, an overflow drives nmiReq high until the flag is cleared, and irqInterval stays low.
- R7: When bit 6 is 1 and bit 3 is 1, an overflow produces a single-cycle rstReq pulse. After the pulse, the status register and the counter both read 0x00.
- R8: When bit 4 is 0, clock-select bits [2:0] with codes 0 to 7 give one count per 2, 64, 128, 512, 2048, 8192, 32768 and 131072 main-clock cycles.
- R9: When bit 4 is 1, the same codes give one count per 2, 4, 8, 16, 32, 64, 128 and 256 sub-clock pulses.
- R10: A status write (busAddr 0) takes effect only when busWdata[15:8] is 0xA5. A write with any other key changes nothing.
- R11: A counter write (busAddr 1) loads busWdata[7:0] only when busWdata[15:8] is 0x5A. A write with any other key leaves the count unchanged.
- R12: After reset, both registers read 0x00 and all three request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Active-low synchronous reset |
| subTick | input | 1 | One-cycle sub-clock enable pulse |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 1 | 0 = control/status, 1 = counter |
| busWdata | input | 16 | Key in [15:8], value in [7:0] |
| busRdata | output | 8 | Read data of the addressed register |
| irqInterval | output | 1 | Interval-timer interrupt request |
| nmiReq | output | 1 | Watchdog NMI request |
| rstReq | output | 1 | Watchdog internal reset pulse |

## Verification
The count rate is measured as the number of cycles between two successive counter changes. This is done for main-chain codes 0, 1 and 4 and for sub-chain codes 0, 3 and 7, with a sub-clock pulse every third cycle. A wrong bit in either divide table, or a swapped chain, gives a different gap. The flag-clearing rules are probed with three sequences: a write of 0 without a prior read, a write of 1 after a read, and a write of 0 after a read. Only the last of these may drop the request. Overflow is forced by loading 0xFE under each of the three mode settings, so that the interrupt, the NMI and the reset paths can each be told apart from the others. Keys are tested by swapping the two valid key values between the two registers.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CNT_W = 8;
  localparam logic [7:0] CSR_KEY = 8'hA5;
  localparam logic [7:0] CNT_KEY = 8'h5A;

  typedef struct packed {
    logic       enable;
    logic       subSel;
    logic [2:0] cks;
  } tick_cfg_t;

  typedef struct packed {
    logic             clear;
    logic             load;
    logic [CNT_W-1:0] loadVal;
  } cnt_strobe_t;

  // log2 of the main-chain divide ratio for each clock-select code
  function automatic int mainShift(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 6;
      3'd2:    return 7;
      3'd3:    return 9;
      3'd4:    return 11;
      3'd5:    return 13;
      3'd6:    return 15;
      default: return 17;
    endcase
  endfunction

  // log2 of the sub-chain divide ratio
  function automatic int subShift(input logic [2:0] code);
    return int'(code) + 1;
  endfunction
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int MAIN_W = 17,
  parameter int SUB_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             subTick,
  input  tick_cfg_t        cfg,
  input  cnt_strobe_t      strb,
  output logic [CNT_W-1:0] cntVal,
  output logic             ovfEvent
);
  logic [MAIN_W-1:0] mainDiv, mainMask;
  logic [SUB_W-1:0]  subDiv, subMask;
  logic [CNT_W-1:0]  cnt;
  logic              tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainDiv <= '0;
      subDiv  <= '0;
    end else begin
      mainDiv <= mainDiv + 1'b1;
      if (subTick) subDiv <= subDiv + 1'b1;
    end
  end

  always_comb begin
    mainMask = '0;
    for (int i = 0; i < MAIN_W; i++)
      if (i < mainShift(cfg.cks)) mainMask[i] = 1'b1;
    subMask = '0;
    for (int i = 0; i < SUB_W; i++)
      if (i < subShift(cfg.cks)) subMask[i] = 1'b1;
  end

  always_comb begin
    if (cfg.subSel) tick = subTick && ((subDiv & subMask) == subMask);
    else            tick = (mainDiv & mainMask) == mainMask;
  end

  assign ovfEvent = !strb.clear && !strb.load && tick && (cnt == '1);
  assign cntVal   = cnt;

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (strb.clear) cnt <= '0;
    else if (strb.load)  cnt <= strb.loadVal;
    else if (tick)       cnt <= cnt + 1'b1;
  end

  p_off_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.enable |=> cnt == '0);
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvent |=> cnt == '0);
  p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clear && !strb.load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic [15:0]      busWdata,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             ovfEvent,
  output logic [7:0]       busRdata,
  output tick_cfg_t        cfg,
  output cnt_strobe_t      strb,
  output logic             irqInterval,
  output logic             nmiReq,
  output logic             rstReq
);
  logic ovf, wdMode, enable, subSel, rstSel, ovfSeen, rstPulse;
  logic [2:0] cks;
  logic csrWr, cntWr, csrRd, ovfClr;

  assign csrWr  = busSel && busWr && !busAddr && (busWdata[15:8] == CSR_KEY);
  assign cntWr  = busSel && busWr &&  busAddr && (busWdata[15:8] == CNT_KEY);
  assign csrRd  = busSel && !busWr && !busAddr;
  assign ovfClr = csrWr && (!busWdata[5] || (!busWdata[7] && ovfSeen));

  always_ff @(posedge clk) begin
    if (!rstN || rstPulse) begin
      ovf <= 1'b0; wdMode <= 1'b0; enable <= 1'b0; subSel <= 1'b0;
      rstSel <= 1'b0; cks <= '0; ovfSeen <= 1'b0; rstPulse <= 1'b0;
    end else begin
      rstPulse <= ovfEvent && wdMode && rstSel;
      if (csrWr) begin
        wdMode <= busWdata[6];
        enable <= busWdata[5];
        subSel <= busWdata[4];
        rstSel <= busWdata[3];
        cks    <= busWdata[2:0];
      end
      if (ovfEvent)    ovf <= 1'b1;
      else if (ovfClr) ovf <= 1'b0;
      if (ovfClr && !ovfEvent) ovfSeen <= 1'b0;
      else if (csrRd && ovf)   ovfSeen <= 1'b1;
    end
  end

  assign cfg          = '{enable: enable, subSel: subSel, cks: cks};
  assign strb.clear   = !enable || rstPulse;
  assign strb.load    = cntWr;
  assign strb.loadVal = busWdata[CNT_W-1:0];

  assign busRdata    = busAddr ? cntVal : {ovf, wdMode, enable, subSel, rstSel, cks};
  assign irqInterval = ovf && !wdMode;
  assign nmiReq      = ovf && wdMode && !rstSel;
  assign rstReq      = rstPulse;

  p_ovf_set_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvent && !rstPulse) |=> ovf);
  p_blind_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !ovfSeen && !rstPulse && !(csrWr && !busWdata[5])) |=> ovf);
  p_req_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(irqInterval && nmiReq));
  p_rst_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    rstPulse |=> (!rstPulse && !enable && !ovf));
  p_key_guard_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !busAddr && busWdata[15:8] != CSR_KEY && !rstPulse)
      |=> $stable({wdMode, enable, subSel, rstSel, cks}));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int MAIN_DIV_W = 17,
  parameter int SUB_DIV_W  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        subTick,
  input  logic        busSel,
  input  logic        busWr,
  input  logic        busAddr,
  input  logic [15:0] busWdata,
  output logic [7:0]  busRdata,
  output logic        irqInterval,
  output logic        nmiReq,
  output logic        rstReq
);
  tick_cfg_t        cfg;
  cnt_strobe_t      strb;
  logic [CNT_W-1:0] cntVal;
  logic             ovfEvent;

  wdt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .cntVal(cntVal), .ovfEvent(ovfEvent),
    .busRdata(busRdata), .cfg(cfg), .strb(strb),
    .irqInterval(irqInterval), .nmiReq(nmiReq), .rstReq(rstReq)
  );

  wdt_datapath #(.MAIN_W(MAIN_DIV_W), .SUB_W(SUB_DIV_W)) u_dp (
    .clk(clk), .rstN(rstN), .subTick(subTick), .cfg(cfg), .strb(strb),
    .cntVal(cntVal), .ovfEvent(ovfEvent)
  );
endmodule

// File: tb/wdt_timer_test.sv
module wdt_timer_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic subTick = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0, busAddr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [7:0] busRdata;
  logic irqInterval, nmiReq, rstReq;
  int nChecks = 0, nFail = 0, rstHigh = 0, subPh = 0;

  always #4 clk = ~clk;

  wdt_timer uut (
    .clk(clk), .rstN(rstN), .subTick(subTick), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqInterval(irqInterval), .nmiReq(nmiReq), .rstReq(rstReq)
  );

  always @(negedge clk) begin
    if (subPh == 2) begin subPh = 0; subTick = 1'b1; end
    else begin subPh = subPh + 1; subTick = 1'b0; end
    if (rstReq) rstHigh = rstHigh + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic addr, input logic [7:0] key, input logic [7:0] val);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWdata = {key, val};
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic addr, output logic [7:0] val);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = addr;
    #1 val = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measurePeriod(input string req, input logic [7:0] csr, input int expGap);
    logic [7:0] prev, cur;
    int gap;
    busWrite(1'b0, 8'hA5, csr);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 1'b1;
    #1 prev = busRdata;
    do begin @(negedge clk); #1 cur = busRdata; end while (cur == prev);
    prev = cur; gap = 0;
    do begin @(negedge clk); #1 cur = busRdata; gap++; end while (cur == prev);
    busSel = 1'b0;
    check(req, $sformatf("gap csr=%0h", csr), gap, expGap);
    busWrite(1'b0, 8'hA5, 8'h00);
  endtask

  task automatic testReset();
    logic [7:0] v;
    busRead(1'b0, v); check("R12", "csr after reset", v, 0);
    busRead(1'b1, v); check("R12", "cnt after reset", v, 0);
    check("R12", "requests after reset", {irqInterval, nmiReq, rstReq}, 0);
  endtask

  task automatic testRates();
    measurePeriod("R8", 8'h20, 2);
    measurePeriod("R8", 8'h21, 64);
    measurePeriod("R8", 8'h24, 2048);
    measurePeriod("R9", 8'h30, 6);
    measurePeriod("R9", 8'h33, 48);
    measurePeriod("R9", 8'h37, 768);
  endtask

  task automatic testIntervalFlag();
    logic [7:0] v;
    busWrite(1'b0, 8'hA5, 8'h20);
    busWrite(1'b1, 8'h5A, 8'hFE);
    waitCycles(8);
    check("R5", "irq after overflow", irqInterval, 1);
    check("R5", "nmi/rst in interval mode", {nmiReq, rstReq}, 0);
    busWrite(1'b0, 8'hA5, 8'h20);
    check("R3", "irq after unread write 0", irqInterval, 1);
    busRead(1'b0, v);
    check("R1", "flag bit7 set", v & 8'h80, 8'h80);
    busWrite(1'b0, 8'hA5, 8'hA0);
    check("R3", "irq after write 1", irqInterval, 1);
    busWrite(1'b0, 8'hA5, 8'h20);
    check("R3", "irq after read then write 0", irqInterval, 0);
  endtask

  task automatic testDisableClears();
    logic [7:0] v;
    busWrite(1'b1, 8'h5A, 8'hFE);
    waitCycles(8);
    check("R4", "irq before disable", irqInterval, 1);
    busWrite(1'b0, 8'hA5, 8'h00);
    check("R4", "irq after disable", irqInterval, 0);
    busRead(1'b1, v); check("R2", "cnt after disable", v, 0);
    waitCycles(20);
    busRead(1'b1, v); check("R2", "cnt stays 0 while off", v, 0);
  endtask

  task automatic testNmi();
    busWrite(1'b0, 8'hA5, 8'h60);
    busWrite(1'b1, 8'h5A, 8'hFE);
    waitCycles(8);
    check("R6", "nmi after overflow", nmiReq, 1);
    check("R6", "irq in watchdog mode", irqInterval, 0);
    waitCycles(5);
    check("R6", "nmi held", nmiReq, 1);
    busWrite(1'b0, 8'hA5, 8'h40);
    check("R6", "nmi after disable", nmiReq, 0);
  endtask

  task automatic testWatchdogReset();
    logic [7:0] v;
    rstHigh = 0;
    busWrite(1'b0, 8'hA5, 8'h68);
    busWrite(1'b1, 8'h5A, 8'hFE);
    waitCycles(10);
    check("R7", "reset pulse cycles", rstHigh, 1);
    busRead(1'b0, v); check("R7", "csr after reset pulse", v, 0);
    busRead(1'b1, v); check("R7", "cnt after reset pulse", v, 0);
  endtask

  task automatic testKeys();
    logic [7:0] v;
    busWrite(1'b0, 8'h5A, 8'h3F);
    busRead(1'b0, v); check("R10", "csr with wrong key", v, 0);
    busWrite(1'b0, 8'hA5, 8'h37);
    busWrite(1'b1, 8'h5A, 8'h40);
    busRead(1'b1, v); check("R11", "cnt keyed load", v, 8'h40);
    busWrite(1'b1, 8'hA5, 8'h10);
    busRead(1'b1, v); check("R11", "cnt with wrong key", v, 8'h40);
    busWrite(1'b0, 8'hA5, 8'h00);
  endtask

  initial begin
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(2);
    testReset();
    testRates();
    testIntervalFlag();
    testDisableClears();
    testNmi();
    testWatchdogReset();
    testKeys();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule